// File: doc/BRIEF.md
# Prioritised Physical-Memory Permission Checker

This block decides whether a single memory request may proceed. It is given the request's start address, byte count, the permissions it needs (read, write, execute) and whether it comes from machine mode. It is also given an already-decoded table of protection entries, where each entry is an inclusive low/high byte window, an active flag and a four-bit configuration. The block walks the table from entry 0 upward. The lowest-numbered active entry that touches the request settles the outcome. When no active entry touches the request, a default policy applies, chosen by two security controls: a lockdown control and a default-deny control.

The result is a grant flag, the mask of permissions the deciding rule allows, the index of the deciding entry, and a no-match flag. The decision logic is combinational. A parameter can add one register stage on the outputs, and that stage resets synchronously. Range decoding from configuration registers, translation caching and trap generation belong to the surrounding logic.

Top module: `prio_perm_checker`

## Requirements
- R1: Entries are examined in ascending index order. The lowest-numbered active entry that contains the first byte or the last byte of the request decides the result, and `hit_idx` reports its index.
- R2: The last byte is start + effective size − 1, modulo 2^AW. If the deciding entry contains only one of the first and last bytes, the request is denied, `allow` is 000 and `no_match` is 0.
- R3: With lockdown off, a fully contained request takes `allow` = 111 when it is from machine mode and the entry's lock bit is clear. Otherwise `allow` is the entry's R/W/X bits. Configuration bits are bit0 R, bit1 W, bit2 X and bit3 lock. Permission masks are bit0 R, bit1 W and bit2 X.
- R4: With lockdown on, a machine-mode request uses the index k = {lock,R,W,X}, and `allow` is set as follows:
  - k 2, 3 and 14 give RW.
  - k 9 and 10 give X.
  - k 11 and 13 give RX.
  - k 12 and 15 give R.
  - Every other k gives none.
- R5: With lockdown on, a non-machine request uses the same index k, and `allow` is set as follows:
  - k 7 gives RWX.
  - k 5 gives RX.
  - k 3 and 6 give RW.
  - k 2, 4 and 15 give R.
  - k 1, 10 and 11 give X.
  - Every other k gives none.
- R6: When nothing matches and default-deny is on, the request is denied with `allow` = 000, whatever the lockdown setting.
- R7: When nothing matches, default-deny is off and lockdown is on, a machine-mode request that does not ask for X is granted with `allow` = 011. Every other request is denied with `allow` = 000.
- R8: When nothing matches and both controls are off, a machine-mode request is granted with `allow` = 111. A non-machine request is denied with `allow` = 000.
- R9: On a fully contained match, `grant` is 1 exactly when every requested bit is set in `allow`.
- R10: A request size of 0 stands for XLEN/8 bytes.
- R11: With REG_OUT = 1, the outputs show the decision one clock after the inputs. While reset is held, the outputs read grant 0, allow 000, hit_idx 0 and no_match 1.
- R12: When `no_match` is 1, `hit_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage and the checks |
| rst_n | input | 1 | Synchronous active-low reset |
| req_addr | input | AW | First byte address of the request |
| req_size | input | SZW | Byte count; 0 means XLEN/8 |
| req_perm | input | 3 | Requested permissions {X,W,R} |
| req_mach | input | 1 | 1 when the request is from machine mode |
| lockdown_en | input | 1 | Selects the lockdown permission tables and default |
| deny_default | input | 1 | Denies every request that matches no entry |
| ent_lo | input | ENTRIES*AW | Inclusive low byte address of each entry |
| ent_hi | input | ENTRIES*AW | Inclusive high byte address of each entry |
| ent_on | input | ENTRIES | Active flag of each entry |
| ent_cfg | input | ENTRIES*4 | Per entry {lock,X,W,R} |
| grant | output | 1 | Request allowed |
| allow | output | 3 | Allowed permission mask {X,W,R} |
| hit_idx | output | $clog2(ENTRIES) | Index of the deciding entry |
| no_match | output | 1 | No active entry touched the request |

## Verification
The bench builds the checker with 16 entries, a 16-bit address space, a 4-bit size field, XLEN 32 and the output register enabled. The narrow address space makes random windows overlap often, so random traffic regularly hits priority conflicts, partial overlaps and address wrap-around. The output register makes the reset value and the one-cycle latency visible at the ports. All 32 lockdown table cells are swept directly, in both modes.

// File: rtl/prio_pmp_pkg.sv
// Shared types and permission tables for the prioritised permission checker.
// Assumes permission masks are {X,W,R} and configuration nibbles {lock,X,W,R}.
package prio_pmp_pkg;

    typedef logic [2:0] perm_t;

    localparam perm_t PERM_NONE = 3'b000;
    localparam perm_t PERM_R    = 3'b001;
    localparam perm_t PERM_RW   = 3'b011;
    localparam perm_t PERM_X    = 3'b100;
    localparam perm_t PERM_RX   = 3'b101;
    localparam perm_t PERM_RWX  = 3'b111;

    typedef struct packed {
        logic lock;
        logic x;
        logic w;
        logic r;
    } ent_cfg_t;

    // Builds the lockdown table index {lock,R,W,X}.
    function automatic logic [3:0] lockdown_key(ent_cfg_t c);
        return {c.lock, c.r, c.w, c.x};
    endfunction

    // Lockdown permissions granted to machine-mode requests.
    function automatic perm_t mach_lockdown(logic [3:0] k);
        perm_t p;
        case (k)
            4'd2, 4'd3, 4'd14: p = PERM_RW;
            4'd9, 4'd10:       p = PERM_X;
            4'd11, 4'd13:      p = PERM_RX;
            4'd12, 4'd15:      p = PERM_R;
            default:           p = PERM_NONE;
        endcase
        return p;
    endfunction

    // Lockdown permissions granted to non-machine requests.
    function automatic perm_t user_lockdown(logic [3:0] k);
        perm_t p;
        case (k)
            4'd7:                p = PERM_RWX;
            4'd5:                p = PERM_RX;
            4'd3, 4'd6:          p = PERM_RW;
            4'd2, 4'd4, 4'd15:   p = PERM_R;
            4'd1, 4'd10, 4'd11:  p = PERM_X;
            default:             p = PERM_NONE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pmp_range_probe.sv
// Compares the first and last byte of a request with one inclusive window.
// Assumes lo and hi are byte addresses; a window with lo > hi contains nothing.
module pmp_range_probe #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] win_lo,
    input  logic [AW-1:0] win_hi,
    input  logic [AW-1:0] first_b,
    input  logic [AW-1:0] last_b,
    output logic          head_in,
    output logic          tail_in
);

    // Containment test for both ends of the request.
    always_comb begin
        head_in = (first_b >= win_lo) && (first_b <= win_hi);
        tail_in = (last_b  >= win_lo) && (last_b  <= win_hi);
    end

endmodule

// File: rtl/pmp_first_hit.sv
// Picks the lowest-numbered active entry touching the request and says whether
// it holds the whole request. Assumes ENTRIES >= 2.
module pmp_first_hit #(
    parameter int ENTRIES = 16,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] on,
    input  logic [ENTRIES-1:0] head,
    input  logic [ENTRIES-1:0] tail,
    output logic               found,
    output logic               full,
    output logic [IW-1:0]      idx
);

    // Descending scan so the lowest touching index overrides the rest.
    always_comb begin
        found = 1'b0;
        full  = 1'b0;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (on[i] && (head[i] || tail[i])) begin
                found = 1'b1;
                full  = head[i] && tail[i];
                idx   = IW'(i);
            end
        end
    end

    // R1: a reported hit names an active entry that touches the request.
    assert_hit_touches_R1: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (on[idx] && (head[idx] || tail[idx])));

    // R1: with no hit, no active entry may touch the request.
    assert_miss_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> ((on & (head | tail)) == '0));

endmodule

// File: rtl/pmp_perm_resolve.sv
// Turns the selected entry (or its absence) into an allowed mask and a grant.
// Assumes 'full' is only meaningful when 'found' is set.
module pmp_perm_resolve
    import prio_pmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     found,
    input  logic     full,
    input  ent_cfg_t cfg,
    input  perm_t    need,
    input  logic     mach,
    input  logic     lockdown,
    input  logic     deny_all,
    output perm_t    allow,
    output logic     grant
);

    perm_t rule_allow;

    // Permission of a fully containing entry under the active rule set.
    always_comb begin
        if (!lockdown)
            rule_allow = (mach && !cfg.lock) ? PERM_RWX : {cfg.x, cfg.w, cfg.r};
        else if (mach)
            rule_allow = mach_lockdown(lockdown_key(cfg));
        else
            rule_allow = user_lockdown(lockdown_key(cfg));
    end

    // Final decision: partial overlap, rule match, or default policy.
    always_comb begin
        if (found && !full) begin
            allow = PERM_NONE;
            grant = 1'b0;
        end else if (found) begin
            allow = rule_allow;
            grant = ((need & ~rule_allow) == PERM_NONE);
        end else if (deny_all) begin
            allow = PERM_NONE;
            grant = 1'b0;
        end else if (lockdown) begin
            grant = mach && !need[2];
            allow = grant ? PERM_RW : PERM_NONE;
        end else begin
            grant = mach;
            allow = mach ? PERM_RWX : PERM_NONE;
        end
    end

    // R2: partial overlap never grants or allows anything.
    assert_partial_deny_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !full) |-> (!grant && allow == PERM_NONE));

    // R9: a grant never exceeds the allowed mask.
    assert_grant_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ((need & ~allow) == PERM_NONE));

    // R6: default-deny with no match closes everything.
    assert_default_deny_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!found && deny_all) |-> (!grant && allow == PERM_NONE));

    // R7: the lockdown default never hands out execute.
    assert_lock_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!found && !deny_all && lockdown) |-> (allow[2] == 1'b0));

endmodule

// File: rtl/prio_perm_checker.sv
// Top of the prioritised permission checker: computes the request's last byte,
// probes every entry, selects the first touching one and resolves permissions.
// Assumes entry windows are already decoded; REG_OUT adds one output register.
module prio_perm_checker
    import prio_pmp_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int AW      = 32,
    parameter int SZW     = 8,
    parameter int XLEN    = 32,
    parameter bit REG_OUT = 1'b0,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         req_addr,
    input  logic [SZW-1:0]        req_size,
    input  logic [2:0]            req_perm,
    input  logic                  req_mach,
    input  logic                  lockdown_en,
    input  logic                  deny_default,
    input  logic [ENTRIES*AW-1:0] ent_lo,
    input  logic [ENTRIES*AW-1:0] ent_hi,
    input  logic [ENTRIES-1:0]    ent_on,
    input  logic [ENTRIES*4-1:0]  ent_cfg,
    output logic                  grant,
    output logic [2:0]            allow,
    output logic [IW-1:0]         hit_idx,
    output logic                  no_match
);

    localparam logic [AW-1:0] WORD_BYTES = AW'(XLEN / 8);

    logic [AW-1:0]      last_b;
    logic [ENTRIES-1:0] head, tail;
    logic               found, full;
    logic [IW-1:0]      sel_idx;
    ent_cfg_t           sel_cfg;
    perm_t              c_allow;
    logic               c_grant;

    // Last byte of the request, with size 0 meaning one native word.
    always_comb begin
        if (req_size == '0)
            last_b = req_addr + WORD_BYTES - AW'(1);
        else
            last_b = req_addr + AW'(req_size) - AW'(1);
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_probe
        pmp_range_probe #(.AW(AW)) u_probe (
            .win_lo  (ent_lo[g*AW +: AW]),
            .win_hi  (ent_hi[g*AW +: AW]),
            .first_b (req_addr),
            .last_b  (last_b),
            .head_in (head[g]),
            .tail_in (tail[g])
        );
    end

    pmp_first_hit #(.ENTRIES(ENTRIES)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .on    (ent_on),
        .head  (head),
        .tail  (tail),
        .found (found),
        .full  (full),
        .idx   (sel_idx)
    );

    // Configuration of the selected entry.
    always_comb sel_cfg = ent_cfg_t'(ent_cfg[sel_idx*4 +: 4]);

    pmp_perm_resolve u_resolve (
        .clk      (clk),
        .rst_n    (rst_n),
        .found    (found),
        .full     (full),
        .cfg      (sel_cfg),
        .need     (req_perm),
        .mach     (req_mach),
        .lockdown (lockdown_en),
        .deny_all (deny_default),
        .allow    (c_allow),
        .grant    (c_grant)
    );

    if (REG_OUT) begin : g_reg
        // One-stage output register, cleared to a closed decision in reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                grant    <= 1'b0;
                allow    <= PERM_NONE;
                hit_idx  <= '0;
                no_match <= 1'b1;
            end else begin
                grant    <= c_grant;
                allow    <= c_allow;
                hit_idx  <= sel_idx;
                no_match <= !found;
            end
        end
    end else begin : g_comb
        // Direct combinational outputs.
        always_comb begin
            grant    = c_grant;
            allow    = c_allow;
            hit_idx  = sel_idx;
            no_match = !found;
        end
    end

    // R12: an unmatched result carries index zero.
    assert_idx_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        no_match |-> (hit_idx == '0));

endmodule

// File: tb/test_prio_perm_checker.sv
`timescale 1ns/1ps
module test_prio_perm_checker;

    localparam int E = 16;
    localparam int AW = 16;
    localparam int SZW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [AW-1:0] req_addr = '0;
    logic [SZW-1:0] req_size = '0;
    logic [2:0] req_perm = '0;
    logic req_mach = 1'b0, lockdown_en = 1'b0, deny_default = 1'b0;
    logic [AW-1:0] lo_q [E];
    logic [AW-1:0] hi_q [E];
    logic [3:0] cfg_q [E];
    logic [E-1:0] on_q = '0;
    logic [E*AW-1:0] ent_lo, ent_hi;
    logic [E*4-1:0] ent_cfg;
    logic grant, no_match;
    logic [2:0] allow;
    logic [3:0] hit_idx;

    int checks = 0, fails = 0;
    bit done = 0;

    always_comb begin
        for (int i = 0; i < E; i++) begin
            ent_lo[i*AW +: AW] = lo_q[i];
            ent_hi[i*AW +: AW] = hi_q[i];
            ent_cfg[i*4 +: 4] = cfg_q[i];
        end
    end

    prio_perm_checker #(.ENTRIES(E), .AW(AW), .SZW(SZW), .XLEN(32), .REG_OUT(1'b1)) i_prio_perm_checker (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_size(req_size),
        .req_perm(req_perm), .req_mach(req_mach), .lockdown_en(lockdown_en),
        .deny_default(deny_default), .ent_lo(ent_lo), .ent_hi(ent_hi),
        .ent_on(on_q), .ent_cfg(ent_cfg), .grant(grant), .allow(allow),
        .hit_idx(hit_idx), .no_match(no_match));

    function automatic logic [2:0] tb_mach(input logic [3:0] k);
        if (k == 4'd12 || k == 4'd15) return 3'b001;
        if (k == 4'd11 || k == 4'd13) return 3'b101;
        if (k == 4'd9 || k == 4'd10) return 3'b100;
        if (k == 4'd2 || k == 4'd3 || k == 4'd14) return 3'b011;
        return 3'b000;
    endfunction

    function automatic logic [2:0] tb_user(input logic [3:0] k);
        if (k == 4'd5) return 3'b101;
        if (k == 4'd7) return 3'b111;
        if (k == 4'd3 || k == 4'd6) return 3'b011;
        if (k == 4'd1 || k == 4'd10 || k == 4'd11) return 3'b100;
        if (k == 4'd2 || k == 4'd4 || k == 4'd15) return 3'b001;
        return 3'b000;
    endfunction

    // Expected result from the requirements.
    function automatic void ref_model(output logic g, output logic [2:0] al,
                                      output logic [3:0] ix, output logic nm);
        logic [AW-1:0] last;
        logic s, e;
        logic [3:0] c;
        last = req_addr + ((req_size == 0) ? 16'd4 : {12'd0, req_size}) - 16'd1;
        for (int i = 0; i < E; i++) begin
            s = (req_addr >= lo_q[i]) && (req_addr <= hi_q[i]);
            e = (last >= lo_q[i]) && (last <= hi_q[i]);
            if (on_q[i] && (s || e)) begin
                nm = 0; ix = 4'(i); c = cfg_q[i];
                if (!(s && e)) begin al = 0; g = 0; end
                else begin
                    if (!lockdown_en) al = (req_mach && !c[3]) ? 3'b111 : c[2:0];
                    else if (req_mach) al = tb_mach({c[3], c[0], c[1], c[2]});
                    else al = tb_user({c[3], c[0], c[1], c[2]});
                    g = ((req_perm & ~al) == 3'b000);
                end
                return;
            end
        end
        nm = 1; ix = 0;
        if (deny_default) begin g = 0; al = 0; end
        else if (lockdown_en) begin g = req_mach && !req_perm[2]; al = g ? 3'b011 : 3'b000; end
        else begin g = req_mach; al = req_mach ? 3'b111 : 3'b000; end
    endfunction

    task automatic expect_out(input string tag, input logic g, input logic [2:0] al,
                              input logic [3:0] ix, input logic nm);
        checks++;
        if (grant !== g || allow !== al || hit_idx !== ix || no_match !== nm) begin
            fails++;
            $display("FAIL %s: got grant=%b allow=%b idx=%0d nm=%b, expected grant=%b allow=%b idx=%0d nm=%b",
                     tag, grant, allow, hit_idx, no_match, g, al, ix, nm);
        end
    endtask

    // Drives a request after a falling edge and waits past the capturing edge.
    task automatic send(input logic [AW-1:0] a, input logic [SZW-1:0] sz,
                        input logic [2:0] p, input logic m);
        @(negedge clk);
        req_addr = a; req_size = sz; req_perm = p; req_mach = m;
        @(negedge clk);
    endtask

    task automatic send_check(input string tag, input logic [AW-1:0] a,
                              input logic [SZW-1:0] sz, input logic [2:0] p, input logic m);
        logic g, nm; logic [2:0] al; logic [3:0] ix;
        send(a, sz, p, m);
        ref_model(g, al, ix, nm);
        expect_out(tag, g, al, ix, nm);
    endtask

    task automatic clear_table();
        for (int i = 0; i < E; i++) begin lo_q[i] = 0; hi_q[i] = 0; cfg_q[i] = 0; end
        on_q = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        logic g0, nm0; logic [2:0] al0; logic [3:0] ix0;
        int r;
        r = $urandom(32'h5EED_1234);
        clear_table();
        // R11: reset value while reset is held.
        repeat (3) @(negedge clk);
        expect_out("R11 reset", 1'b0, 3'b000, 4'd0, 1'b1);
        rst_n = 1'b1;

        // R8: empty table, both controls off.
        send_check("R8 mach default", 16'h1234, 4'd2, 3'b111, 1'b1);
        expect_out("R8 mach explicit", 1'b1, 3'b111, 4'd0, 1'b1);
        send_check("R8 user default", 16'h1234, 4'd2, 3'b001, 1'b0);
        expect_out("R8 user explicit", 1'b0, 3'b000, 4'd0, 1'b1);

        // R7: lockdown default.
        lockdown_en = 1;
        send_check("R7 mach read", 16'h0040, 4'd1, 3'b011, 1'b1);
        expect_out("R7 mach read explicit", 1'b1, 3'b011, 4'd0, 1'b1);
        send_check("R7 mach exec", 16'h0040, 4'd1, 3'b100, 1'b1);
        send_check("R7 user read", 16'h0040, 4'd1, 3'b001, 1'b0);

        // R6: default-deny dominates.
        deny_default = 1;
        send_check("R6 lock+deny", 16'h0040, 4'd1, 3'b001, 1'b1);
        lockdown_en = 0;
        send_check("R6 deny only", 16'h0040, 4'd1, 3'b000, 1'b1);
        expect_out("R6 deny explicit", 1'b0, 3'b000, 4'd0, 1'b1);
        deny_default = 0;

        // R1: overlapping entries, lower index decides.
        lo_q[2] = 16'h1000; hi_q[2] = 16'h10FF; cfg_q[2] = 4'b0001;
        lo_q[5] = 16'h0F00; hi_q[5] = 16'h1FFF; cfg_q[5] = 4'b0111;
        on_q[2] = 1; on_q[5] = 1;
        send_check("R1 priority", 16'h1010, 4'd4, 3'b010, 1'b0);
        expect_out("R1 priority explicit", 1'b0, 3'b001, 4'd2, 1'b0);
        send_check("R1 lower entry", 16'h1200, 4'd4, 3'b011, 1'b0);
        expect_out("R1 lower entry explicit", 1'b1, 3'b111, 4'd5, 1'b0);

        // R2: straddling the top of entry 2 is denied even though entry 5 covers it.
        send_check("R2 partial", 16'h10FE, 4'd4, 3'b000, 1'b1);
        expect_out("R2 partial explicit", 1'b0, 3'b000, 4'd2, 1'b0);

        // R3: lock bit in machine mode without lockdown.
        send_check("R3 unlocked mach", 16'h1000, 4'd1, 3'b110, 1'b1);
        expect_out("R3 unlocked explicit", 1'b1, 3'b111, 4'd2, 1'b0);
        cfg_q[2] = 4'b1001;
        send_check("R3 locked mach", 16'h1000, 4'd1, 3'b010, 1'b1);
        expect_out("R3 locked explicit", 1'b0, 3'b001, 4'd2, 1'b0);

        // R10: size 0 means four bytes.
        clear_table();
        lo_q[0] = 16'h0100; hi_q[0] = 16'h0103; cfg_q[0] = 4'b0111; on_q[0] = 1;
        send_check("R10 word fits", 16'h0100, 4'd0, 3'b001, 1'b0);
        expect_out("R10 word fits explicit", 1'b1, 3'b111, 4'd0, 1'b0);
        send_check("R10 word straddles", 16'h0101, 4'd0, 3'b001, 1'b0);
        expect_out("R10 word straddles explicit", 1'b0, 3'b000, 4'd0, 1'b0);

        // R11: output holds the old decision until the next edge.
        @(negedge clk);
        req_addr = 16'h0100; req_size = 4'd0;
        #1;
        expect_out("R11 latency hold", 1'b0, 3'b000, 4'd0, 1'b0);
        @(negedge clk);
        expect_out("R11 latency update", 1'b1, 3'b111, 4'd0, 1'b0);

        // R4 and R5: full lockdown table sweep.
        lockdown_en = 1;
        lo_q[0] = 16'h0000; hi_q[0] = 16'hFFFF;
        for (int k = 0; k < 16; k++) begin
            cfg_q[0] = {k[3], k[0], k[1], k[2]};
            send_check("R4 mach table", 16'h2000, 4'd4, 3'b111, 1'b1);
            send_check("R5 user table", 16'h2000, 4'd4, 3'b111, 1'b0);
            send_check("R9 user single", 16'h2000, 4'd4, 3'(1 << (k % 3)), 1'b0);
        end
        send(16'h2000, 4'd4, 3'b101, 1'b0);
        ref_model(g0, al0, ix0, nm0);
        expect_out("R5 k15 explicit", 1'b0, 3'b001, 4'd0, 1'b0);

        // Random mix for R1, R2, R9, R12.
        for (int n = 0; n < 3000; n++) begin
            clear_table();
            for (int i = 0; i < E; i++) begin
                lo_q[i] = 16'($urandom);
                hi_q[i] = lo_q[i] + 16'($urandom_range(0, 4095));
                cfg_q[i] = 4'($urandom);
                on_q[i] = ($urandom_range(0, 3) != 0);
            end
            lockdown_en = 1'($urandom);
            deny_default = ($urandom_range(0, 5) == 0);
            send_check("R9 random", 16'($urandom), 4'($urandom), 3'($urandom), 1'($urandom));
        end
        finish_run();
    end

endmodule